// File: doc/BRIEF.md
# BCD Calendar with Alarm

This block keeps the wall-clock time and the calendar date: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A once-per-second strobe starts an update cycle. The cycle steps the time forward by one second, with every carry from seconds up to the year and with leap-year February. After a hold-off of a fixed number of timebase ticks, the new time is copied into the visible time registers and checked against a three-field alarm. Each update ends with an update-ended event, plus interrupt-request events when they are enabled.

Inside, the time is kept in binary. The visible registers can be plain binary or BCD, and the hour can be 24-hour or 12-hour with a PM flag. Each encoding is a combinational conversion on the way in and on the way out. A freeze input lets software rewrite the registers without the running clock overwriting them, and the registers are reloaded when the freeze ends. The block has no data stream, so there is no valid/ready handshake. Every pin is a plain level or a one-cycle strobe, and writes are never back-pressured.

Top module: `rtcal_core`

## Requirements
- R1: One completed update advances the time by one second. Seconds and minutes wrap from 59 to 0, hours wrap from 23 to 0, and the day of week (visible 1..7) wraps from 7 to 1. The month (1..12) wraps from 12 to 1, and the two-digit year wraps from 99 to 0.
- R2: Month lengths are 31 days, except April, June, September and November with 30, and February with 28. February has 29 days when the full year (BASE_YEAR plus the stored year) is divisible by 4, and either not by 100 or by 400.
- R3: With `bin_mode`=0 each visible field is BCD: tens digit in bits 7:4, units digit in bits 3:0. With `bin_mode`=1 each field is plain binary.
- R4: With `h24_mode`=0 the hour field holds the hour modulo 12, with bit 7 set for hours 12 to 23. Noon reads 0x80 and midnight reads 0x00. On load, bit 7 adds 12 to the value decoded from bits 6:0.
- R5: A `sec_tick` starts an update only when `osc_sel` equals 3'b010. Any other value skips that second: no advance and no events.
- R6: At the edge that accepts `sec_tick`, `uip` rises unless `hold` is high. It falls after UIP_TICKS `ref_tick` pulses, at the same edge where the visible registers take the new time. While `hold` is high, `uip` is low from the next cycle on.
- R7: While `hold` is high, updates still advance the internal time, but the visible fields change only through writes. When `hold` falls, the internal time is reloaded from the visible fields, and any advance made during the freeze is discarded.
- R8: Time fields are written with `wr_en`, using `wr_sel` codes seconds 0, minutes 1, hours 2, day of week 3, day of month 4, month 5, year 6. A write with `hold` low reloads the internal time from the visible fields.
- R9: When `bin_mode` or `h24_mode` changes while `hold` is low, the visible fields are re-encoded in the new format one cycle later.
- R10: Alarm fields are written with `wr_sel` codes seconds 8, minutes 9, hours 10. A field matches when bits 7:6 are both 1 (wildcard) or when its decoded value equals the new time. When all three fields match and `alarm_en` is high, `af_pulse` and `irqf_pulse` both pulse at the end of the update.
- R11: Every completed update pulses `uf_pulse`. `irqf_pulse` also pulses when `upd_irq_en` is high.
- R12: After reset the visible fields read seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, day of month 0x01, month 0x01, year 0x00. `uip` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| ref_tick | input | 1 | Timebase strobe that paces the update hold-off |
| osc_sel | input | 3 | Oscillator control; 3'b010 lets time run |
| hold | input | 1 | Freeze visible registers (set mode) |
| bin_mode | input | 1 | 1 = binary fields, 0 = BCD |
| h24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| alarm_en | input | 1 | Enable alarm event |
| upd_irq_en | input | 1 | Enable interrupt on update end |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 4 | Field select code |
| wr_data | input | 8 | Field write value, visible format |
| out_sec | output | 8 | Visible seconds |
| out_min | output | 8 | Visible minutes |
| out_hr | output | 8 | Visible hours |
| out_dow | output | 8 | Visible day of week |
| out_dom | output | 8 | Visible day of month |
| out_mon | output | 8 | Visible month |
| out_yr | output | 8 | Visible year |
| uip | output | 1 | Update in progress |
| uf_pulse | output | 1 | Update-ended event |
| af_pulse | output | 1 | Alarm event |
| irqf_pulse | output | 1 | Interrupt-request event |

## Verification
The embedded assertions watch the cycle-level rules on every clock. `hold` clears `uip`, and a falling `uip` coincides with the update-ended event. An update only starts with the oscillator field in its run code, and an alarm event always carries an interrupt request. The visible fields stay fixed under `hold` unless written, and carries and BCD digits stay in range. The arithmetic itself can only be shown by the bench's scenarios with known answers: the year-end and month-end rollovers, leap and non-leap Februaries, 12-hour noon and midnight, re-encoding on a format change, and the wildcard alarm matches.

// File: rtl/rtcal_pkg.sv
package rtcal_pkg;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [6:0] hr;
    logic [2:0] dow;   // 0..6
    logic [4:0] dom;   // 1..31
    logic [3:0] mon;   // 1..12
    logic [6:0] yr;    // 0..99
  } caltime_t;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hr;
    logic [7:0] dow;
    logic [7:0] dom;
    logic [7:0] mon;
    logic [7:0] yr;
  } calvis_t;

  localparam logic [3:0] SEL_SEC  = 4'd0;
  localparam logic [3:0] SEL_MIN  = 4'd1;
  localparam logic [3:0] SEL_HR   = 4'd2;
  localparam logic [3:0] SEL_DOW  = 4'd3;
  localparam logic [3:0] SEL_DOM  = 4'd4;
  localparam logic [3:0] SEL_MON  = 4'd5;
  localparam logic [3:0] SEL_YR   = 4'd6;
  localparam logic [3:0] SEL_ASEC = 4'd8;
  localparam logic [3:0] SEL_AMIN = 4'd9;
  localparam logic [3:0] SEL_AHR  = 4'd10;

  // binary value (0..99) to visible byte
  function automatic logic [7:0] to_vis(input logic [6:0] v, input logic bin);
    logic [6:0] tens, ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
  endfunction

  // visible byte to binary value
  function automatic logic [6:0] from_vis(input logic [7:0] x, input logic bin);
    return bin ? x[6:0] : (7'(x[7:4]) * 7'd10 + 7'(x[3:0]));
  endfunction

  function automatic logic [7:0] hour_to_vis(input logic [6:0] h, input logic bin,
                                             input logic h24);
    if (h24) return to_vis(h, bin);
    return to_vis(h % 7'd12, bin) | ((h >= 7'd12) ? 8'h80 : 8'h00);
  endfunction

  function automatic logic [6:0] hour_from_vis(input logic [7:0] x, input logic bin,
                                               input logic h24);
    logic [6:0] base;
    base = from_vis({1'b0, x[6:0]}, bin);
    return (!h24 && x[7]) ? base + 7'd12 : base;
  endfunction

  function automatic logic is_leap(input logic [6:0] yr, input int base_year);
    int full;
    full = base_year + int'(yr);
    return ((full % 4) == 0) && (((full % 100) != 0) || ((full % 400) == 0));
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic leap);
    case (mon)
      4'd2:                       return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:    return 5'd30;
      default:                    return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtcal_advance.sv
module rtcal_advance
  import rtcal_pkg::*;
#(
  parameter int BASE_YEAR = 2000
) (
  input  caltime_t cur,
  output caltime_t nxt
);
  logic [4:0] dim;

  always_comb begin
    dim = month_days(cur.mon, is_leap(cur.yr, BASE_YEAR));
    nxt = cur;
    if (cur.sec >= 7'd59) begin
      nxt.sec = '0;
      if (cur.min >= 7'd59) begin
        nxt.min = '0;
        if (cur.hr >= 7'd23) begin
          nxt.hr  = '0;
          nxt.dow = (cur.dow >= 3'd6) ? 3'd0 : cur.dow + 3'd1;
          if (cur.dom >= dim) begin
            nxt.dom = 5'd1;
            if (cur.mon >= 4'd12) begin
              nxt.mon = 4'd1;
              nxt.yr  = (cur.yr >= 7'd99) ? 7'd0 : cur.yr + 7'd1;
            end else begin
              nxt.mon = cur.mon + 4'd1;
            end
          end else begin
            nxt.dom = cur.dom + 5'd1;
          end
        end else begin
          nxt.hr = cur.hr + 7'd1;
        end
      end else begin
        nxt.min = cur.min + 7'd1;
      end
    end else begin
      nxt.sec = cur.sec + 7'd1;
    end
  end

  // R1: legal inputs never carry out of range
  always_comb begin
    if (cur.sec < 7'd60)
      a_r1_sec_range: assert (nxt.sec < 7'd60) else $error("R1 seconds out of range");
    if (cur.hr < 7'd24)
      a_r1_hr_range: assert (nxt.hr < 7'd24) else $error("R1 hours out of range");
    if (cur.mon >= 4'd1 && cur.mon <= 4'd12)
      a_r2_mon_range: assert (nxt.mon >= 4'd1 && nxt.mon <= 4'd12)
        else $error("R2 month out of range");
  end
endmodule

// File: rtl/rtcal_encode.sv
module rtcal_encode
  import rtcal_pkg::*;
(
  input  caltime_t t,
  input  logic     bin,
  input  logic     h24,
  output calvis_t  v
);
  always_comb begin
    v.sec = to_vis(t.sec, bin);
    v.min = to_vis(t.min, bin);
    v.hr  = hour_to_vis(t.hr, bin, h24);
    v.dow = to_vis(7'(t.dow) + 7'd1, bin);
    v.dom = to_vis(7'(t.dom), bin);
    v.mon = to_vis(7'(t.mon), bin);
    v.yr  = to_vis(t.yr, bin);
  end

  // R3: BCD units digit stays a decimal digit
  always_comb begin
    if (!bin && t.sec < 7'd60)
      a_r3_bcd_digit: assert (v.sec[3:0] < 4'd10) else $error("R3 bad BCD digit");
  end
endmodule

// File: rtl/rtcal_alarm.sv
module rtcal_alarm
  import rtcal_pkg::*;
(
  input  logic [7:0] a_sec,
  input  logic [7:0] a_min,
  input  logic [7:0] a_hr,
  input  logic [6:0] t_sec,
  input  logic [6:0] t_min,
  input  logic [6:0] t_hr,
  input  logic       bin,
  input  logic       h24,
  output logic       hit
);
  logic m_sec, m_min, m_hr;

  always_comb begin
    m_sec = (a_sec[7:6] == 2'b11) || (from_vis(a_sec, bin) == t_sec);
    m_min = (a_min[7:6] == 2'b11) || (from_vis(a_min, bin) == t_min);
    m_hr  = (a_hr[7:6]  == 2'b11) || (hour_from_vis(a_hr, bin, h24) == t_hr);
    hit   = m_sec && m_min && m_hr;
  end
endmodule

// File: rtl/rtcal_core.sv
module rtcal_core
  import rtcal_pkg::*;
#(
  parameter int         BASE_YEAR = 2000,
  parameter int         UIP_TICKS = 8,
  parameter logic [2:0] OSC_RUN   = 3'b010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       ref_tick,
  input  logic [2:0] osc_sel,
  input  logic       hold,
  input  logic       bin_mode,
  input  logic       h24_mode,
  input  logic       alarm_en,
  input  logic       upd_irq_en,
  input  logic       wr_en,
  input  logic [3:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] out_sec,
  output logic [7:0] out_min,
  output logic [7:0] out_hr,
  output logic [7:0] out_dow,
  output logic [7:0] out_dom,
  output logic [7:0] out_mon,
  output logic [7:0] out_yr,
  output logic       uip,
  output logic       uf_pulse,
  output logic       af_pulse,
  output logic       irqf_pulse
);
  localparam int CW = $clog2(UIP_TICKS + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(UIP_TICKS - 1);

  caltime_t   now_t, adv_t, vis_dec;
  calvis_t    vis, enc_v;
  logic [7:0] alm_sec, alm_min, alm_hr;
  logic       bin_q, h24_q, hold_q;
  logic       reload_pend, copy_pend, busy;
  logic [CW-1:0] cnt;
  logic       alm_hit;
  logic       fmt_chg, time_wr, start, finish, copy_now;

  rtcal_advance #(.BASE_YEAR(BASE_YEAR)) u_adv (.cur(now_t), .nxt(adv_t));

  rtcal_encode u_enc (.t(now_t), .bin(bin_mode), .h24(h24_mode), .v(enc_v));

  rtcal_alarm u_alm (
    .a_sec(alm_sec), .a_min(alm_min), .a_hr(alm_hr),
    .t_sec(now_t.sec), .t_min(now_t.min), .t_hr(now_t.hr),
    .bin(bin_q), .h24(h24_q), .hit(alm_hit)
  );

  // visible registers decoded in the format they were written in
  always_comb begin
    vis_dec.sec = from_vis(vis.sec, bin_q);
    vis_dec.min = from_vis(vis.min, bin_q);
    vis_dec.hr  = hour_from_vis(vis.hr, bin_q, h24_q);
    vis_dec.dow = 3'(from_vis(vis.dow, bin_q) - 7'd1);
    vis_dec.dom = 5'(from_vis(vis.dom, bin_q));
    vis_dec.mon = 4'(from_vis(vis.mon, bin_q));
    vis_dec.yr  = from_vis(vis.yr, bin_q);
  end

  always_comb begin
    fmt_chg  = (bin_mode != bin_q) || (h24_mode != h24_q);
    time_wr  = wr_en && (wr_sel <= SEL_YR);
    start    = !busy && sec_tick && (osc_sel == OSC_RUN);
    finish   = busy && ref_tick && (cnt == LAST_CNT);
    copy_now = !hold && ((finish) || ((fmt_chg || copy_pend) && !reload_pend));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_t.sec <= '0; now_t.min <= '0; now_t.hr <= '0; now_t.dow <= '0;
      now_t.dom <= 5'd1; now_t.mon <= 4'd1; now_t.yr <= '0;
      vis.sec <= 8'h00; vis.min <= 8'h00; vis.hr <= 8'h00; vis.dow <= 8'h01;
      vis.dom <= 8'h01; vis.mon <= 8'h01; vis.yr <= 8'h00;
      alm_sec <= '0; alm_min <= '0; alm_hr <= '0;
      bin_q <= 1'b0; h24_q <= 1'b1; hold_q <= 1'b0;
      reload_pend <= 1'b0; copy_pend <= 1'b0;
      busy <= 1'b0; cnt <= '0; uip <= 1'b0;
      uf_pulse <= 1'b0; af_pulse <= 1'b0; irqf_pulse <= 1'b0;
    end else begin
      bin_q  <= bin_mode;
      h24_q  <= h24_mode;
      hold_q <= hold;
      uf_pulse <= 1'b0; af_pulse <= 1'b0; irqf_pulse <= 1'b0;

      reload_pend <= (time_wr && !hold) || (hold_q && !hold);
      copy_pend   <= !hold && (fmt_chg || copy_pend) && reload_pend && !finish;

      // copy-out, then writes (a write in the same cycle wins)
      if (copy_now) vis <= enc_v;
      if (wr_en) begin
        case (wr_sel)
          SEL_SEC:  vis.sec <= wr_data;
          SEL_MIN:  vis.min <= wr_data;
          SEL_HR:   vis.hr  <= wr_data;
          SEL_DOW:  vis.dow <= wr_data;
          SEL_DOM:  vis.dom <= wr_data;
          SEL_MON:  vis.mon <= wr_data;
          SEL_YR:   vis.yr  <= wr_data;
          SEL_ASEC: alm_sec <= wr_data;
          SEL_AMIN: alm_min <= wr_data;
          SEL_AHR:  alm_hr  <= wr_data;
          default: ;
        endcase
      end

      if (reload_pend)  now_t <= vis_dec;
      else if (start)   now_t <= adv_t;

      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
        uip  <= !hold;
      end else if (busy && ref_tick) begin
        cnt <= cnt + 1'b1;
        if (finish) begin
          busy       <= 1'b0;
          uip        <= 1'b0;
          uf_pulse   <= 1'b1;
          af_pulse   <= alarm_en && alm_hit;
          irqf_pulse <= upd_irq_en || (alarm_en && alm_hit);
        end
      end
      if (hold) uip <= 1'b0;
    end
  end

  assign out_sec = vis.sec;
  assign out_min = vis.min;
  assign out_hr  = vis.hr;
  assign out_dow = vis.dow;
  assign out_dom = vis.dom;
  assign out_mon = vis.mon;
  assign out_yr  = vis.yr;

  a_r6_hold_clears_uip: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !uip) else $error("R6 uip high under hold");

  a_r6_uip_ends_with_update: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(uip) && !$past(hold)) |-> uf_pulse) else $error("R6 uip fell without update end");

  a_r5_start_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(osc_sel) == OSC_RUN)) else $error("R5 update started while stopped");

  a_r10_alarm_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    af_pulse |-> irqf_pulse) else $error("R10 alarm without interrupt request");

  a_r7_frozen_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hold) && !$past(wr_en)) |-> $stable(vis)) else $error("R7 visible changed under hold");

endmodule

// File: tb/test_rtcal_core.sv
module test_rtcal_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0, ref_tick = 1'b1;
  logic [2:0] osc_sel = 3'b010;
  logic       hold = 1'b0, bin_mode = 1'b0, h24_mode = 1'b1;
  logic       alarm_en = 1'b0, upd_irq_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] out_sec, out_min, out_hr, out_dow, out_dom, out_mon, out_yr;
  logic       uip, uf_pulse, af_pulse, irqf_pulse;

  int checks = 0, fails = 0;
  int n_uf = 0, n_af = 0, n_irq = 0;

  always #5 clk = ~clk;

  rtcal_core i_rtcal_core (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .ref_tick(ref_tick),
    .osc_sel(osc_sel), .hold(hold), .bin_mode(bin_mode), .h24_mode(h24_mode),
    .alarm_en(alarm_en), .upd_irq_en(upd_irq_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .out_sec(out_sec), .out_min(out_min), .out_hr(out_hr),
    .out_dow(out_dow), .out_dom(out_dom), .out_mon(out_mon), .out_yr(out_yr),
    .uip(uip), .uf_pulse(uf_pulse), .af_pulse(af_pulse), .irqf_pulse(irqf_pulse)
  );

  always @(negedge clk) begin
    if (uf_pulse)   n_uf++;
    if (af_pulse)   n_af++;
    if (irqf_pulse) n_irq++;
  end

  // fields packed as {sec,min,hr,dow,dom,mon,yr}; mode = {bin_mode,h24_mode}
  typedef struct packed {
    logic [1:0]  mode;
    logic [55:0] din;
    logic [55:0] dexp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 56'h59_59_23_07_31_12_99, 56'h00_00_00_01_01_01_00},  // R1 year end
    '{2'b01, 56'h30_15_10_03_15_06_24, 56'h31_15_10_03_15_06_24},  // R1 plain second
    '{2'b01, 56'h59_59_23_04_28_02_24, 56'h00_00_00_05_29_02_24},  // R2 leap Feb 28
    '{2'b01, 56'h59_59_23_02_28_02_23, 56'h00_00_00_03_01_03_23},  // R2 common Feb
    '{2'b01, 56'h59_59_23_05_29_02_24, 56'h00_00_00_06_01_03_24},  // R2 leap Feb 29
    '{2'b01, 56'h59_59_23_01_28_02_00, 56'h00_00_00_02_29_02_00},  // R2 year 2000
    '{2'b01, 56'h59_59_23_06_30_04_24, 56'h00_00_00_07_01_05_24},  // R2 30-day month
    '{2'b01, 56'h59_09_19_03_09_09_24, 56'h00_10_19_03_09_09_24},  // R3 BCD minute carry
    '{2'b00, 56'h59_59_11_02_10_01_24, 56'h00_00_80_02_10_01_24},  // R4 noon
    '{2'b00, 56'h59_59_91_02_10_01_24, 56'h00_00_00_03_11_01_24},  // R4 midnight
    '{2'b11, 56'h3B_3B_17_07_1F_0C_63, 56'h00_00_00_01_01_01_00},  // R3 binary year end
    '{2'b10, 56'h3B_3B_8B_01_1C_02_17, 56'h00_00_00_02_01_03_17},  // R4 binary 12h
    '{2'b10, 56'h3B_3B_0B_01_05_03_17, 56'h00_00_80_01_05_03_17},  // R4 binary noon
    '{2'b00, 56'h59_59_81_04_10_01_24, 56'h00_00_82_04_10_01_24}   // R4 PM hour step
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
    cyc(1);
  endtask

  task automatic load(input logic [1:0] mode, input logic [55:0] t);
    hold = 1'b1;
    cyc(1);
    bin_mode = mode[1]; h24_mode = mode[0];
    cyc(2);
    for (int i = 0; i < 7; i++) wr(4'(i), t[55-8*i -: 8]);
    hold = 1'b0;
    cyc(3);
  endtask

  task automatic second();
    sec_tick = 1'b1;
    cyc(1);
    sec_tick = 1'b0;
    cyc(20);
  endtask

  function automatic logic [55:0] visible();
    return {out_sec, out_min, out_hr, out_dow, out_dom, out_mon, out_yr};
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    int b_uf, b_af, b_irq;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R12 reset values
    check("R12 reset fields", 64'(visible()), 64'h00_00_00_01_01_01_00);
    check("R12 reset uip", 64'(uip), 64'd0);

    // table of vectors: load, one second, compare all fields
    for (int k = 0; k < NV; k++) begin
      load(VECS[k].mode, VECS[k].din);
      second();
      check($sformatf("R1 R2 R3 R4 vector %0d", k), 64'(visible()), 64'(VECS[k].dexp));
    end

    // R6 uip window
    load(2'b01, 56'h30_15_10_03_15_06_24);
    sec_tick = 1'b1;
    cyc(1);
    sec_tick = 1'b0;
    check("R6 uip raised", 64'(uip), 64'd1);
    cyc(3);
    check("R6 uip still high", 64'(uip), 64'd1);
    check("R6 no copy during uip", 64'(out_sec), 64'h30);
    cyc(10);
    check("R6 uip cleared", 64'(uip), 64'd0);
    check("R6 copy at end", 64'(out_sec), 64'h31);

    // R5 oscillator gating
    b_uf = n_uf;
    osc_sel = 3'b011;
    second();
    check("R5 stopped: time", 64'(out_sec), 64'h31);
    check("R5 stopped: no update event", 64'(n_uf - b_uf), 64'd0);
    osc_sel = 3'b010;

    // R7 freeze and reload
    load(2'b01, 56'h30_15_10_03_15_06_24);
    hold = 1'b1;
    cyc(2);
    b_uf = n_uf;
    sec_tick = 1'b1;
    cyc(1);
    sec_tick = 1'b0;
    check("R7 uip low under hold", 64'(uip), 64'd0);
    cyc(20);
    check("R7 visible frozen", 64'(out_sec), 64'h30);
    check("R11 update event under hold", 64'(n_uf - b_uf), 64'd1);
    hold = 1'b0;
    cyc(3);
    second();
    check("R7 reload discards hidden advance", 64'(out_sec), 64'h31);

    // R8 write reloads at once
    wr(4'd0, 8'h45);
    cyc(2);
    second();
    check("R8 write then second", 64'(out_sec), 64'h46);

    // R9 format change re-encodes
    load(2'b01, 56'h30_45_15_03_15_06_24);
    h24_mode = 1'b0;
    cyc(3);
    check("R9 12h hour", 64'(out_hr), 64'h83);
    bin_mode = 1'b1;
    cyc(3);
    check("R9 binary fields", 64'({out_sec, out_min, out_hr}), 64'h1E_2D_83);
    bin_mode = 1'b0; h24_mode = 1'b1;
    cyc(3);
    check("R9 back to BCD 24h", 64'(out_hr), 64'h15);

    // R10 alarm matching
    wr(4'd8, 8'h31); wr(4'd9, 8'hC0); wr(4'd10, 8'hFF);
    alarm_en = 1'b1;
    load(2'b01, 56'h30_15_10_03_15_06_24);
    b_af = n_af; b_irq = n_irq;
    second();
    check("R10 wildcard match af", 64'(n_af - b_af), 64'd1);
    check("R10 wildcard match irq", 64'(n_irq - b_irq), 64'd1);
    wr(4'd8, 8'h45);
    b_af = n_af;
    second();
    check("R10 seconds mismatch", 64'(n_af - b_af), 64'd0);
    wr(4'd8, 8'hC0); wr(4'd9, 8'h15); wr(4'd10, 8'h10);
    b_af = n_af;
    second();
    check("R10 exact hour minute match", 64'(n_af - b_af), 64'd1);
    alarm_en = 1'b0;
    b_af = n_af; b_irq = n_irq;
    second();
    check("R10 alarm disabled af", 64'(n_af - b_af), 64'd0);
    check("R10 alarm disabled irq", 64'(n_irq - b_irq), 64'd0);

    // R11 update-ended interrupt
    upd_irq_en = 1'b1;
    b_uf = n_uf; b_irq = n_irq;
    second();
    check("R11 update event", 64'(n_uf - b_uf), 64'd1);
    check("R11 irq with enable", 64'(n_irq - b_irq), 64'd1);
    upd_irq_en = 1'b0;

    finish_run();
  end

endmodule